// File: doc/BRIEF.md
# I2S Transmit Serializer with Word Unpacking

This block drives the three wires of an I2S transmitter: a bit clock, a word-select line and a serial data line. It draws 32-bit words from a show-ahead transmit FIFO and splits each word into audio samples. A two-bit width code sets the sample size to 8, 16 or 32 bits. Each sample is shifted out MSB first in standard I2S alignment. The bit clock comes from an internal toggle flop. An external enable pulse advances it by one half period, so the enable rate sets the audio bit rate.

The block works in stereo mode, where samples alternate between the left and right channels, or in mono mode, where each sample is played on both channels. A mute control sends zero samples but keeps draining the FIFO. A stop control sends zeros and leaves the FIFO untouched. When the FIFO runs dry, the block keeps sending the most recent sample and does not fall silent. A synchronous reset input restarts the framing. Software must pulse it whenever the width code or the mode changes.

Top module: `i2s_tx_serializer`

## Requirements
- R1: After reset (either `rst_n` low or `cfg_reset` high), `sck`, `ws` and `sd` are low and `fifo_pop` is low.
- R2: `sck` toggles only on a clock edge where `sck_en` is high. `ws` and `sd` change only on the falling transition of `sck`.
- R3: The `ws` half period is exactly the sample width in `sck` periods. A sample's MSB appears one `sck` period after `ws` changes, so its LSB goes out while `ws` already shows the next channel.
- R4: Width code 0 splits a FIFO word into four 8-bit samples, sent in the order bits [7:0], [15:8], [23:16], [31:24].
- R5: Width code 1 splits a word into two 16-bit samples, bits [15:0] first and then bits [31:16]. Width code 2 behaves exactly like code 1.
- R6: Width code 3 sends each FIFO word as one 32-bit sample. In stereo mode, one word supplies the left sample and the next word supplies the right sample.
- R7: In stereo mode, consecutive samples alternate left (`ws`=0) then right (`ws`=1), starting with left after a reset.
- R8: In mono mode, each sample is sent on the left phase and then repeated on the right phase.
- R9: `fifo_pop` pulses only while `fifo_empty` is low, and only when the current word holds no unsent sample. If the FIFO is empty at that point, the previously sent sample is sent again.
- R10: While `cfg_mute` is high, every sample carries the value zero, and FIFO words are still consumed at the normal rate.
- R11: While `cfg_stop` is high, the data line carries zeros and no FIFO word is popped.
- R12: Releasing `cfg_reset` restarts the framing, so the first sample received afterwards is the first slot of the FIFO head word, on the left channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_en | input | 1 | Bit-clock half-period advance pulse |
| cfg_reset | input | 1 | Synchronous framing reset, pulsed after a width or mode change |
| cfg_width | input | 2 | Sample width code: 0=8 bit, 1 or 2=16 bit, 3=32 bit |
| cfg_mono | input | 1 | 1 = mono, each sample on both channels |
| cfg_mute | input | 1 | 1 = send zero samples, keep consuming the FIFO |
| cfg_stop | input | 1 | 1 = send zeros, do not consume the FIFO |
| fifo_data | input | 32 | Head word of the show-ahead FIFO |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_pop | output | 1 | Consume the head word this cycle |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, 0 = left, 1 = right |
| sd | output | 1 | Serial data, changes on the falling `sck` edge |

## Verification
The collision that matters is a sample load that falls on the same edge where the held word runs out. At that edge the unpacker has to choose between popping a fresh word and repeating the last sample, and in mono mode it also has to choose between reusing the current sample and advancing. Directed tests load the FIFO with exactly one or two words so that this edge arrives with the FIFO empty. A decoder in the bench rebuilds the received samples from `sck`, `ws` and `sd`, and checks both the repeated values and the read-pointer count against slices computed in the bench.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  localparam int WORD_W = 32;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int BITS_W = CNT_W + 1;

  typedef enum logic [1:0] {
    WC_BYTE  = 2'd0,
    WC_HALF  = 2'd1,
    WC_HALF2 = 2'd2,
    WC_WORD  = 2'd3
  } width_code_e;

  // sample width in bits for a width code (code 2 aliases code 1)
  function automatic logic [BITS_W-1:0] sample_bits(input logic [1:0] code);
    case (code)
      WC_BYTE: sample_bits = BITS_W'(8);
      WC_WORD: sample_bits = BITS_W'(32);
      default: sample_bits = BITS_W'(16);
    endcase
  endfunction

  // number of samples packed in one FIFO word
  function automatic logic [2:0] slots_per_word(input logic [1:0] code);
    case (code)
      WC_BYTE: slots_per_word = 3'd4;
      WC_WORD: slots_per_word = 3'd1;
      default: slots_per_word = 3'd2;
    endcase
  endfunction

  // pick slot idx out of a word, returned MSB-aligned in a full word
  function automatic logic [WORD_W-1:0] slot_msb_aligned(input logic [WORD_W-1:0] w,
                                                         input logic [1:0] code,
                                                         input logic [1:0] idx);
    case (code)
      WC_BYTE: slot_msb_aligned = {w[{idx, 3'b000} +: 8], 24'b0};
      WC_WORD: slot_msb_aligned = w;
      default: slot_msb_aligned = {w[{idx[0], 4'b0000} +: 16], 16'b0};
    endcase
  endfunction

endpackage

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen
  import i2s_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              sck_en,
  input  logic [BITS_W-1:0] wbits,
  output logic              sck,
  output logic              ws,
  output logic              fall_tick,
  output logic              wrap,
  output logic              next_left
);

  logic             sck_q, ws_q, half_q, first_q;
  logic [CNT_W-1:0] bitc_q;
  logic             last_bit;

  assign last_bit  = ({1'b0, bitc_q} == wbits - BITS_W'(1));
  assign fall_tick = sck_en && sck_q && !soft_rst;
  assign wrap      = fall_tick && (first_q || last_bit);
  assign next_left = half_q;
  assign sck       = sck_q;
  assign ws        = ws_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; ws_q <= 1'b0; half_q <= 1'b1; first_q <= 1'b1; bitc_q <= '0;
    end else if (soft_rst) begin
      sck_q <= 1'b0; ws_q <= 1'b0; half_q <= 1'b1; first_q <= 1'b1; bitc_q <= '0;
    end else if (sck_en) begin
      sck_q <= ~sck_q;
      if (sck_q) begin
        ws_q <= wrap ? ~half_q : half_q;
        if (wrap) begin
          half_q  <= ~half_q;
          first_q <= 1'b0;
          bitc_q  <= '0;
        end else begin
          bitc_q  <= bitc_q + 1'b1;
        end
      end
    end
  end

  // R2: the bit clock moves only when enabled (or when forced by reset)
  a_r2_sck_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck_q) |-> ($past(sck_en) || $past(soft_rst)));

  // R2: word select moves only at a falling bit-clock transition
  a_r2_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws_q) |-> ($past(fall_tick) || $past(soft_rst)));

  // R3: a half frame never runs past the sample width
  a_r3_count_in_width: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    {1'b0, bitc_q} < wbits);

endmodule

// File: rtl/i2s_tx_unpack.sv
module i2s_tx_unpack
  import i2s_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              load,
  input  logic              to_left,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_mono,
  input  logic              cfg_stop,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  output logic [WORD_W-1:0] sample
);

  logic [WORD_W-1:0] word_q, last_q;
  logic [1:0]        idx_q;
  logic [2:0]        avail_q;
  logic              want_new, from_word, underflow;

  // a fresh sample is needed unless stopped or on the mono right phase
  assign want_new  = load && !cfg_stop && !(cfg_mono && !to_left);
  assign from_word = want_new && (avail_q != 3'd0);
  assign fifo_pop  = want_new && (avail_q == 3'd0) && !fifo_empty;
  assign underflow = want_new && (avail_q == 3'd0) && fifo_empty;

  always_comb begin
    if (from_word)      sample = slot_msb_aligned(word_q, cfg_width, idx_q);
    else if (fifo_pop)  sample = slot_msb_aligned(fifo_data, cfg_width, 2'd0);
    else                sample = last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0; last_q <= '0; idx_q <= '0; avail_q <= '0;
    end else if (soft_rst) begin
      word_q <= '0; last_q <= '0; idx_q <= '0; avail_q <= '0;
    end else if (load) begin
      last_q <= sample;
      if (fifo_pop) begin
        word_q  <= fifo_data;
        idx_q   <= 2'd1;
        avail_q <= slots_per_word(cfg_width) - 3'd1;
      end else if (from_word) begin
        idx_q   <= idx_q + 2'd1;
        avail_q <= avail_q - 3'd1;
      end
    end
  end

  // R9: never pop an empty FIFO
  a_r9_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  // R9: pops happen only at a sample load
  a_r9_pop_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> load);

  // R9: on underflow the repeated sample is the one sent before
  a_r9_repeat_last: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (sample == last_q));

  // R11: stopped means the FIFO is left alone
  a_r11_stop_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_stop |-> !fifo_pop);

  // R8: the mono right phase reuses the sample without touching the FIFO
  a_r8_mono_right_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cfg_mono && !to_left) |-> !fifo_pop);

endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter
  import i2s_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              fall_tick,
  input  logic              wrap,
  input  logic              silence,
  input  logic [WORD_W-1:0] sample,
  output logic              sd
);

  logic [WORD_W-1:0] sh_q;
  logic              sd_q;

  assign sd = sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; sd_q <= 1'b0;
    end else if (soft_rst) begin
      sh_q <= '0; sd_q <= 1'b0;
    end else if (fall_tick) begin
      sd_q <= silence ? 1'b0 : sh_q[WORD_W-1];
      sh_q <= wrap ? sample : {sh_q[WORD_W-2:0], 1'b0};
    end
  end

  // R10/R11: a silenced bit period drives zero
  a_r10_silence_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_tick && silence) |=> !sd_q);

  // R2: data moves only at a falling bit-clock transition
  a_r2_sd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_q) |-> ($past(fall_tick) || $past(soft_rst)));

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
  import i2s_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_en,
  input  logic              cfg_reset,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_mono,
  input  logic              cfg_mute,
  input  logic              cfg_stop,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  output logic              sck,
  output logic              ws,
  output logic              sd
);

  logic [BITS_W-1:0] wbits;
  logic              fall_tick, wrap, next_left, silence;
  logic [WORD_W-1:0] sample;

  assign wbits   = sample_bits(cfg_width);
  assign silence = cfg_mute || cfg_stop;

  i2s_tx_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .soft_rst(cfg_reset), .sck_en(sck_en),
    .wbits(wbits), .sck(sck), .ws(ws), .fall_tick(fall_tick),
    .wrap(wrap), .next_left(next_left)
  );

  i2s_tx_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .soft_rst(cfg_reset), .load(wrap),
    .to_left(next_left), .cfg_width(cfg_width), .cfg_mono(cfg_mono),
    .cfg_stop(cfg_stop), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .fifo_pop(fifo_pop), .sample(sample)
  );

  i2s_tx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .soft_rst(cfg_reset), .fall_tick(fall_tick),
    .wrap(wrap), .silence(silence), .sample(sample), .sd(sd)
  );

  // R1: reset leaves all serial outputs low and no pop pending
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_reset) |-> (!sck && !ws && !sd));

endmodule

// File: tb/i2s_tx_serializer_tb_top.sv
`timescale 1ns/1ps
module i2s_tx_serializer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n, sck_en, cfg_reset, cfg_mono, cfg_mute, cfg_stop;
  logic [1:0]  cfg_width;
  logic [31:0] fifo_data;
  logic        fifo_empty, fifo_pop, sck, ws, sd;

  always #2.5 clk = ~clk;

  i2s_tx_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .sck_en(sck_en), .cfg_reset(cfg_reset),
    .cfg_width(cfg_width), .cfg_mono(cfg_mono), .cfg_mute(cfg_mute),
    .cfg_stop(cfg_stop), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .fifo_pop(fifo_pop), .sck(sck), .ws(ws), .sd(sd)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;

  // FIFO model
  logic [31:0] fmem [8];
  logic [3:0]  wr_ptr, rd_ptr;
  logic        fifo_clr;
  assign fifo_empty = (rd_ptr == wr_ptr);
  assign fifo_data  = fmem[rd_ptr[2:0]];
  always @(posedge clk) begin
    if (fifo_clr) rd_ptr <= 4'd0;
    else if (fifo_pop) rd_ptr <= rd_ptr + 4'd1;
  end

  // bit-clock enable driver: period 1 = every cycle
  int en_period = 1, en_cnt = 0;
  logic en_run = 1'b0;
  always @(negedge clk) begin
    en_cnt = (en_cnt + 1 >= en_period) ? 0 : en_cnt + 1;
    sck_en <= en_run && (en_cnt == 0);
  end

  // receiver: rebuilds samples from the serial lines
  logic        dec_clr, prev_sck, prev_ws;
  logic [31:0] shreg;
  int          bitcnt, n_rx;
  logic [31:0] rx_v [16];
  logic        rx_c [16];
  int          rx_n [16];
  always @(negedge clk) begin
    cyc++;
    if (dec_clr) begin
      prev_sck = 1'b0; prev_ws = 1'b0; shreg = '0; bitcnt = 0; n_rx = 0;
    end else begin
      if (sck && !prev_sck) begin
        shreg = {shreg[30:0], sd};
        bitcnt++;
        if (ws != prev_ws) begin
          if (n_rx < 16) begin
            rx_v[n_rx] = shreg; rx_c[n_rx] = prev_ws; rx_n[n_rx] = bitcnt;
          end
          n_rx++;
          bitcnt = 0;
          prev_ws = ws;
        end
      end
      prev_sck = sck;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wbits_of(input logic [1:0] code);
    if (code == 2'd0) return 8;
    if (code == 2'd3) return 32;
    return 16;
  endfunction

  function automatic logic [31:0] mask_of(input int w);
    return (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  task automatic restart(input logic [1:0] wc, input logic mono, input logic mute,
                         input logic stop, input logic [31:0] w0, input logic [31:0] w1,
                         input int nw);
    @(negedge clk);
    cfg_reset = 1'b1; fifo_clr = 1'b1; dec_clr = 1'b1;
    cfg_width = wc; cfg_mono = mono; cfg_mute = mute; cfg_stop = stop;
    fmem[0] = w0; fmem[1] = w1;
    wr_ptr = 4'(nw);
    @(negedge clk); @(negedge clk);
    cfg_reset = 1'b0; fifo_clr = 1'b0; dec_clr = 1'b0;
  endtask

  task automatic wait_rx(input int k);
    int t = 0;
    while (n_rx < k && t < 20000) begin @(negedge clk); t++; end
    if (n_rx < k) check("timeout", 32'(n_rx), 32'(k));
  endtask

  // compare received sample k against an expected value and channel
  task automatic expect_rx(input string req, input int k, input logic [31:0] val,
                           input logic ch, input int w);
    check(req, rx_v[k] & mask_of(w), val & mask_of(w));
    check({req, " R7 channel"}, 32'(rx_c[k]), 32'(ch));
    if (k > 0) check({req, " R3 half period"}, 32'(rx_n[k]), 32'(w));
  endtask

  task automatic t_reset;
    check("R1 sck", 32'(sck), 0);
    check("R1 ws", 32'(ws), 0);
    check("R1 sd", 32'(sd), 0);
    check("R1 pop", 32'(fifo_pop), 0);
  endtask

  task automatic t_stereo16;
    logic [31:0] a = 32'hBEEF_1234, b = 32'h5A5A_C3C3;
    restart(2'd1, 0, 0, 0, a, b, 2);
    wait_rx(7);
    expect_rx("R5 s0", 0, a, 0, 16);
    expect_rx("R5 s1", 1, a >> 16, 1, 16);
    expect_rx("R5 s2", 2, b, 0, 16);
    expect_rx("R5 s3", 3, b >> 16, 1, 16);
    expect_rx("R9 repeat L", 4, b >> 16, 0, 16);
    expect_rx("R9 repeat R", 5, b >> 16, 1, 16);
    check("R9 pops", 32'(rd_ptr), 2);
  endtask

  task automatic t_stereo8;
    logic [31:0] a = 32'hD4C3_B2A1;
    restart(2'd0, 0, 0, 0, a, 32'h0, 1);
    wait_rx(6);
    for (int k = 0; k < 4; k++) expect_rx("R4 byte", k, a >> (8 * k), k[0], 8);
    expect_rx("R9 repeat byte", 4, a >> 24, 0, 8);
  endtask

  task automatic t_stereo32;
    logic [31:0] a = 32'h8001_7FFE, b = 32'h0F0F_F0F1;
    restart(2'd3, 0, 0, 0, a, b, 2);
    wait_rx(4);
    expect_rx("R6 left word", 0, a, 0, 32);
    expect_rx("R6 right word", 1, b, 1, 32);
    expect_rx("R9 repeat word", 2, b, 0, 32);
  endtask

  task automatic t_mono16;
    logic [31:0] a = 32'h9876_0F1E;
    restart(2'd1, 1, 0, 0, a, 32'h0, 1);
    wait_rx(5);
    expect_rx("R8 L0", 0, a, 0, 16);
    expect_rx("R8 R0", 1, a, 1, 16);
    expect_rx("R8 L1", 2, a >> 16, 0, 16);
    expect_rx("R8 R1", 3, a >> 16, 1, 16);
    check("R8 pops", 32'(rd_ptr), 1);
  endtask

  task automatic t_code2;
    logic [31:0] a = 32'h1357_9BDF;
    restart(2'd2, 0, 0, 0, a, 32'h0, 1);
    wait_rx(3);
    expect_rx("R5 code2 s0", 0, a, 0, 16);
    expect_rx("R5 code2 s1", 1, a >> 16, 1, 16);
  endtask

  task automatic t_mute;
    restart(2'd1, 0, 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2);
    wait_rx(5);
    for (int k = 0; k < 4; k++) expect_rx("R10 mute zero", k, 0, k[0], 16);
    check("R10 mute consumes", 32'(rd_ptr), 2);
  endtask

  task automatic t_stop;
    restart(2'd0, 0, 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2);
    wait_rx(5);
    for (int k = 0; k < 4; k++) expect_rx("R11 stop zero", k, 0, k[0], 8);
    check("R11 no pop", 32'(rd_ptr), 0);
    @(negedge clk); cfg_stop = 1'b0;
  endtask

  task automatic t_gapped;
    int toggles = 0;
    logic s0;
    logic [31:0] a = 32'hA55A_3CC3;
    en_period = 3;
    restart(2'd0, 0, 0, 0, a, 32'h0, 1);
    s0 = sck;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (sck != s0) toggles++;
      s0 = sck;
    end
    check("R2 toggle count", 32'(toggles), 20);
    wait_rx(3);
    expect_rx("R2 gapped s0", 0, a, 0, 8);
    expect_rx("R2 gapped s1", 1, a >> 8, 1, 8);
    en_period = 1;
  endtask

  task automatic t_restart;
    logic [31:0] a = 32'h0000_AAAA, b = 32'h7777_1111;
    restart(2'd1, 0, 0, 0, a, 32'h0, 1);
    wait_rx(2);
    restart(2'd1, 0, 0, 0, b, 32'h0, 1);
    check("R12 reset sck", 32'(sck), 0);
    check("R12 reset ws", 32'(ws), 0);
    wait_rx(2);
    expect_rx("R12 first after reset", 0, b, 0, 16);
  endtask

  initial begin
    rst_n = 1'b0; cfg_reset = 1'b0; cfg_width = 2'd1; cfg_mono = 1'b0;
    cfg_mute = 1'b0; cfg_stop = 1'b0; fifo_clr = 1'b1; dec_clr = 1'b1;
    wr_ptr = 4'd0;
    for (int i = 0; i < 8; i++) fmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    fifo_clr = 1'b0; dec_clr = 1'b0;
    en_run = 1'b1;
    t_stereo16();
    t_stereo8();
    t_stereo32();
    t_mono16();
    t_code2();
    t_mute();
    t_stop();
    t_gapped();
    t_restart();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule